// File: doc/BRIEF.md
# Processor Init Pulse Generator

This block merges several independent requests for a processor initialization into one active-low pulse of fixed length. A second output carries the same waveform for a second signalling domain. The requests come from four places: a shutdown event with a policy bit that says whether shutdown should cause an init, two legacy I/O control ports written over a simple write strobe, and an external reset line driven by a keyboard controller.

Each port request is qualified by a rising bit edge. The block compares the written bit with the value it stored from the last write to that port. The external reset line is synchronized and acts on its falling edge. That line has to be seen high again before it can fire a second time. Once a request is accepted, the outputs stay low for a parameterized number of bus clocks, 16 by default.

A clock-stop request freezes the pulse counter, so the pulse grows by the number of cycles the stop is held. A request accepted while the stop is held waits and starts when the stop is released. A request that arrives while a pulse is pending or running is dropped.

Top module: `cpi_init_pulse_gen`

## Requirements
- R1: After reset both outputs are high, and all stored port bits are 0.
- R2: An accepted request drives both outputs low starting at the clock edge that samples it. They stay low for exactly PULSE_LEN (16) edges at which the clock-stop input is low, then return high.
- R3: While the clock-stop input is high, the pulse counter holds its value. A running pulse is lengthened by one cycle for each such edge, and the outputs do not change on an edge that samples the stop high.
- R4: A request accepted while the clock-stop input is high leaves the outputs high. The pulse starts at the first edge that samples the stop low.
- R5: A write to address 0x0092 fires when data bit 0 is 1 and the stored bit 0 is 0. The written bit is then stored, so writing 1 again does not fire.
- R6: A write to address 0x0CF9 fires when data bit 2 is 1 and both stored bits 1 and 2 are 0. Bits 1 and 2 of every such write are stored.
- R7: The external reset input passes through a SYNC_STAGES (2) flop synchronizer. A falling edge of the synchronized input fires, so the pulse starts SYNC_STAGES+1 edges after the input falls. The source is armed after reset, is disarmed by firing, and is re-armed only when the synchronized input goes high.
- R8: The shutdown event fires only when the policy input is 1 in the same cycle. When the policy input is 0 the event has no effect.
- R9: A request that arrives while a pulse is pending or running is ignored, and the pulse is not extended.
- R10: The second output equals the first output in every cycle.
- R11: Writes to any address other than 0x0092 and 0x0CF9 change no stored port bit and fire nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W (16) | I/O write address |
| io_wdata | input | DATA_W (8) | I/O write data |
| kbc_rst_n | input | 1 | External reset request, active low, asynchronous |
| shutdown_evt | input | 1 | One-cycle processor shutdown indication |
| shutdown_sel_init | input | 1 | Policy: 1 means a shutdown causes an init pulse |
| clk_stop_req | input | 1 | Clock-stop request, freezes the pulse counter |
| init_n | output | 1 | Active-low processor init pulse |
| init_alt_n | output | 1 | Copy of init_n for the second signalling domain |

## Verification
A wrong stored port bit shows up on the next write to that port. The write either produces a pulse that should not exist or misses one, and that is visible on the outputs one edge after the write. A wrong pulse counter or state shows as a pulse that starts at the wrong edge or whose length differs from PULSE_LEN plus the held stop cycles. That difference is visible when the pulse ends, at most PULSE_LEN plus the stop cycles later. A wrong arm flag on the external reset line shows as a missing or extra pulse SYNC_STAGES+1 edges after the next falling edge.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

   // Pulse sequencer states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,   // accepted, held off by clock stop
      ST_LOW  = 2'd2    // outputs driven low, counting
   } pulse_st_e;

   // Number of identical init outputs carried by the block
   localparam int unsigned NUM_INIT_OUTS = 2;

endpackage

// File: rtl/cpi_sync.sv
module cpi_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cpi_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= RST_VAL;
            end else begin
               chain_q[s] <= (s == 0) ? d : chain_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cpi_kbc_src.sv
// External reset line source: synchronize, detect falling edge, one-shot arm (R7)
module cpi_kbc_src #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic fire
);

   logic line_s;
   logic line_prev_q;
   logic armed_q;
   logic fall;
   logic rise;

   cpi_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_n),
      .q     (line_s)
   );

   assign fall = line_prev_q & ~line_s;
   assign rise = ~line_prev_q & line_s;
   assign fire = fall & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_prev_q <= 1'b1;
         armed_q     <= 1'b1;
      end else begin
         line_prev_q <= line_s;
         if (fire) begin
            armed_q <= 1'b0;
         end else if (rise) begin
            armed_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpi_port_src.sv
// Legacy I/O port sources with stored bits and 0-to-1 qualification (R5, R6, R11)
module cpi_port_src #(
   parameter int unsigned                ADDR_W         = 16,
   parameter int unsigned                DATA_W         = 8,
   parameter logic [ADDR_W-1:0]          FAST_PORT_ADDR = ADDR_W'('h0092),
   parameter logic [ADDR_W-1:0]          RST_PORT_ADDR  = ADDR_W'('h0CF9),
   parameter int unsigned                FAST_INIT_BIT  = 0,
   parameter int unsigned                RST_SYS_BIT    = 1,
   parameter int unsigned                RST_CPU_BIT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              fire_fast,
   output logic              fire_rst
);

   logic hit_fast;
   logic hit_rst;
   logic fast_bit_q;
   logic sys_bit_q;
   logic cpu_bit_q;

   generate
      if (FAST_INIT_BIT >= DATA_W || RST_SYS_BIT >= DATA_W || RST_CPU_BIT >= DATA_W) begin : g_bad_bits
         $error("cpi_port_src: control bit position outside DATA_W");
      end
      if (FAST_PORT_ADDR == RST_PORT_ADDR) begin : g_bad_addr
         $error("cpi_port_src: port addresses must differ");
      end
   endgenerate

   assign hit_fast = wr && (addr == FAST_PORT_ADDR);
   assign hit_rst  = wr && (addr == RST_PORT_ADDR);

   // R5: compare with the stored bit before it is overwritten
   assign fire_fast = hit_fast && !fast_bit_q && wdata[FAST_INIT_BIT];
   // R6: stored system-reset bit must be 0, cpu bit must rise
   assign fire_rst  = hit_rst && !sys_bit_q && !cpu_bit_q && wdata[RST_CPU_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_bit_q <= 1'b0;
         sys_bit_q  <= 1'b0;
         cpu_bit_q  <= 1'b0;
      end else begin
         if (hit_fast) begin
            fast_bit_q <= wdata[FAST_INIT_BIT];
         end
         if (hit_rst) begin
            sys_bit_q <= wdata[RST_SYS_BIT];
            cpu_bit_q <= wdata[RST_CPU_BIT];
         end
      end
   end

endmodule

// File: rtl/cpi_pulse_timer.sv
// Fixed-length low pulse with clock-stop freeze and deferral (R2, R3, R4, R9, R10)
module cpi_pulse_timer
   import cpi_pkg::*;
#(
   parameter int unsigned PULSE_LEN    = 16,
   parameter int unsigned NUM_OUTS     = 2,
   parameter bit          REPLICATE_FF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                hold,
   output logic [NUM_OUTS-1:0] pulse_n
);

   localparam int unsigned     CNT_W    = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

   pulse_st_e        state_q, state_nxt;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             low_nxt;

   generate
      if (PULSE_LEN < 2) begin : g_bad_len
         $error("cpi_pulse_timer: PULSE_LEN must be at least 2");
      end
      if (NUM_OUTS < 1) begin : g_bad_outs
         $error("cpi_pulse_timer: NUM_OUTS must be at least 1");
      end
   endgenerate

   always_comb begin
      state_nxt = state_q;
      cnt_nxt   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               if (hold) begin
                  state_nxt = ST_WAIT;
               end else begin
                  state_nxt = ST_LOW;
                  cnt_nxt   = '0;
               end
            end
         end
         ST_WAIT: begin
            if (!hold) begin
               state_nxt = ST_LOW;
               cnt_nxt   = '0;
            end
         end
         ST_LOW: begin
            if (!hold) begin
               if (cnt_q == CNT_LAST) begin
                  state_nxt = ST_IDLE;
               end else begin
                  cnt_nxt = cnt_q + 1'b1;
               end
            end
         end
         default: begin
            state_nxt = ST_IDLE;
         end
      endcase
   end

   assign low_nxt = (state_nxt == ST_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_nxt;
         cnt_q   <= cnt_nxt;
      end
   end

   // Output stage: one flop per output, or one shared flop fanned out
   generate
      if (REPLICATE_FF) begin : g_rep
         for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pulse_n[o] <= 1'b1;
               end else begin
                  pulse_n[o] <= ~low_nxt;
               end
            end
         end
      end else begin : g_shared
         logic shared_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shared_n_q <= 1'b1;
            end else begin
               shared_n_q <= ~low_nxt;
            end
         end
         assign pulse_n = {NUM_OUTS{shared_n_q}};
      end
   endgenerate

endmodule

// File: rtl/cpi_init_pulse_gen.sv
module cpi_init_pulse_gen
   import cpi_pkg::*;
#(
   parameter int unsigned       ADDR_W         = 16,
   parameter int unsigned       DATA_W         = 8,
   parameter int unsigned       PULSE_LEN      = 16,
   parameter int unsigned       SYNC_STAGES    = 2,
   parameter logic [ADDR_W-1:0] FAST_PORT_ADDR = ADDR_W'('h0092),
   parameter logic [ADDR_W-1:0] RST_PORT_ADDR  = ADDR_W'('h0CF9),
   parameter int unsigned       FAST_INIT_BIT  = 0,
   parameter int unsigned       RST_SYS_BIT    = 1,
   parameter int unsigned       RST_CPU_BIT    = 2,
   parameter bit                REPLICATE_FF   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              kbc_rst_n,
   input  logic              shutdown_evt,
   input  logic              shutdown_sel_init,
   input  logic              clk_stop_req,
   output logic              init_n,
   output logic              init_alt_n
);

   logic                     fire_fast;
   logic                     fire_rst;
   logic                     fire_kbc;
   logic                     fire_shut;
   logic                     any_req;
   logic [NUM_INIT_OUTS-1:0] pulse_n;

   generate
      if (NUM_INIT_OUTS != 2) begin : g_bad_outs
         $error("cpi_init_pulse_gen: expects exactly two init outputs");
      end
   endgenerate

   cpi_port_src #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .FAST_PORT_ADDR (FAST_PORT_ADDR),
      .RST_PORT_ADDR  (RST_PORT_ADDR),
      .FAST_INIT_BIT  (FAST_INIT_BIT),
      .RST_SYS_BIT    (RST_SYS_BIT),
      .RST_CPU_BIT    (RST_CPU_BIT)
   ) port_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (io_wr),
      .addr      (io_addr),
      .wdata     (io_wdata),
      .fire_fast (fire_fast),
      .fire_rst  (fire_rst)
   );

   cpi_kbc_src #(
      .SYNC_STAGES (SYNC_STAGES)
   ) kbc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (kbc_rst_n),
      .fire   (fire_kbc)
   );

   // R8: shutdown acts only under the init policy
   assign fire_shut = shutdown_evt & shutdown_sel_init;
   assign any_req   = fire_fast | fire_rst | fire_kbc | fire_shut;

   cpi_pulse_timer #(
      .PULSE_LEN    (PULSE_LEN),
      .NUM_OUTS     (NUM_INIT_OUTS),
      .REPLICATE_FF (REPLICATE_FF)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (any_req),
      .hold    (clk_stop_req),
      .pulse_n (pulse_n)
   );

   assign init_n     = pulse_n[0];
   assign init_alt_n = pulse_n[1];

endmodule

// File: rtl/cpi_init_chk.sv
module cpi_init_chk #(
   parameter int unsigned PULSE_LEN = 16
) (
   input logic clk,
   input logic rst_n,
   input logic shutdown_evt,
   input logic shutdown_sel_init,
   input logic clk_stop_req,
   input logic init_n,
   input logic init_alt_n
);

   localparam int unsigned CW = $clog2(PULSE_LEN + 2);

   logic [CW-1:0] low_cnt_q;

   // Counts low cycles that the stop did not freeze
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
      end else if (init_n) begin
         low_cnt_q <= '0;
      end else if (!clk_stop_req && low_cnt_q != {CW{1'b1}}) begin
         low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   // R2
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_n) |-> (low_cnt_q == CW'(PULSE_LEN)));

   // R3
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_req |=> $stable(init_n));

   // R8
   shutdown_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_evt && shutdown_sel_init && init_n && !clk_stop_req) |=> !init_n);

   // R10
   mirror_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_n == init_alt_n);

endmodule

bind cpi_init_pulse_gen cpi_init_chk #(
   .PULSE_LEN (PULSE_LEN)
) chk_i (
   .clk               (clk),
   .rst_n             (rst_n),
   .shutdown_evt      (shutdown_evt),
   .shutdown_sel_init (shutdown_sel_init),
   .clk_stop_req      (clk_stop_req),
   .init_n            (init_n),
   .init_alt_n        (init_alt_n)
);

// File: tb/cpi_init_pulse_gen_tb_top.sv
module cpi_init_pulse_gen_tb_top;

   localparam int LEN  = 16;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        kbc_rst_n = 1'b1;
   logic        shutdown_evt = 1'b0;
   logic        shutdown_sel_init = 1'b0;
   logic        clk_stop_req = 1'b0;
   logic        init_n;
   logic        init_alt_n;

   cpi_init_pulse_gen dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .io_wr             (io_wr),
      .io_addr           (io_addr),
      .io_wdata          (io_wdata),
      .kbc_rst_n         (kbc_rst_n),
      .shutdown_evt      (shutdown_evt),
      .shutdown_sel_init (shutdown_sel_init),
      .clk_stop_req      (clk_stop_req),
      .init_n            (init_n),
      .init_alt_n        (init_alt_n)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    start;
      int    len;
      string tag;
   } exp_t;

   exp_t  sb[$];
   int    n_run  = 0;
   int    n_fail = 0;
   string cur_tag = "R1";
   bit    ended  = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // Monitor: measures each low pulse and compares it with the scoreboard
   bit in_pulse = 1'b0;
   bit mism     = 1'b0;
   int st       = 0;
   int ln       = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (init_alt_n !== init_n) mism = 1'b1;
         if (in_pulse) begin
            if (init_n) begin
               in_pulse = 1'b0;
               if (sb.size() == 0) begin
                  check(1'b0, cur_tag, "unexpected pulse at cycle", st, -1);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(st == e.start, e.tag, "pulse start cycle", st, e.start);
                  check(ln == e.len, e.tag, "pulse length", ln, e.len);
               end
               // R10: second output mirrored throughout the pulse
               check(!mism, "R10", "outputs differed", int'(mism), 0);
               mism = 1'b0;
            end else begin
               ln++;
            end
         end else if (!init_n) begin
            in_pulse = 1'b1;
            st       = cyc;
            ln       = 1;
         end
      end
   end

   // Driver tasks, all entered and left at a falling clock edge
   task automatic expect_pulse(input int delay, input int len, input string tag);
      exp_t e;
      e.start = cyc + delay;
      e.len   = len;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      io_wr    = 1'b1;
      io_addr  = a;
      io_wdata = d;
      @(negedge clk);
      io_wr    = 1'b0;
   endtask

   task automatic shut(input logic sel);
      shutdown_evt      = 1'b1;
      shutdown_sel_init = sel;
      @(negedge clk);
      shutdown_evt      = 1'b0;
      shutdown_sel_init = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string tag);
      idle(LEN + 12);
      check(sb.size() == 0 && init_n && !in_pulse, tag, "expected pulses all seen",
            sb.size(), 0);
   endtask

   initial begin
      #(4 * 200000);
      check(1'b0, "WDOG", "watchdog expired", cyc, 0);
      summary();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R1: outputs idle high after reset
      check(init_n === 1'b1 && init_alt_n === 1'b1, "R1", "outputs after reset",
            {init_n, init_alt_n}, 3);

      // R5 and R1: stored bit 0 starts at 0, so the first write of 1 fires
      cur_tag = "R5";
      expect_pulse(1, LEN, "R5");
      io_write(16'h0092, 8'h01);
      drain("R5");
      io_write(16'h0092, 8'h01);      // bit already 1: no pulse
      drain("R5");
      io_write(16'h0092, 8'h00);
      drain("R5");
      expect_pulse(1, LEN, "R5");
      io_write(16'h0092, 8'h01);
      drain("R5");

      // R11: other addresses leave the stored bit alone (still 1)
      cur_tag = "R11";
      io_write(16'h0093, 8'h00);
      io_write(16'h0080, 8'hFF);
      io_write(16'h0092, 8'h01);      // stored bit still 1: no pulse
      drain("R11");

      // R6: bit 2 rise with stored bits 1 and 2 at 0
      cur_tag = "R6";
      expect_pulse(1, LEN, "R6");
      io_write(16'h0CF9, 8'h04);
      drain("R6");
      io_write(16'h0CF9, 8'h00);
      io_write(16'h0CF9, 8'h02);      // store bit 1 = 1
      io_write(16'h0CF9, 8'h06);      // stored bit 1 set: no pulse
      drain("R6");
      io_write(16'h0CF9, 8'h00);
      expect_pulse(1, LEN, "R6");
      io_write(16'h0CF9, 8'h04);
      drain("R6");

      // R8: shutdown policy
      cur_tag = "R8";
      shut(1'b0);
      drain("R8");
      expect_pulse(1, LEN, "R8");
      shut(1'b1);
      drain("R8");

      // R7: external line, falling edge after synchronizer, one-shot re-arm
      cur_tag = "R7";
      expect_pulse(SYNC + 1, LEN, "R7");
      kbc_rst_n = 1'b0;
      idle(1);
      idle(30);                        // held low: nothing more
      drain("R7");
      kbc_rst_n = 1'b1;
      idle(5);
      drain("R7");
      expect_pulse(SYNC + 1, LEN, "R7");
      kbc_rst_n = 1'b0;
      idle(1);
      drain("R7");
      kbc_rst_n = 1'b1;
      idle(5);

      // R9: second request during a running pulse is dropped
      cur_tag = "R9";
      expect_pulse(1, LEN, "R9");
      shut(1'b1);
      idle(4);
      shut(1'b1);
      io_write(16'h0092, 8'h00);
      io_write(16'h0092, 8'h01);      // fires inside the pulse: ignored
      drain("R9");

      // R2 and R3: stop held 6 cycles mid-pulse lengthens it by 6
      cur_tag = "R3";
      expect_pulse(1, LEN + 6, "R3");
      shut(1'b1);
      idle(4);
      clk_stop_req = 1'b1;
      idle(6);
      clk_stop_req = 1'b0;
      drain("R3");

      // R4: request during stop waits for release
      cur_tag = "R4";
      clk_stop_req = 1'b1;
      shut(1'b1);
      idle(7);
      check(init_n === 1'b1, "R4", "output during stop", int'(init_n), 1);
      expect_pulse(1, LEN, "R4");
      clk_stop_req = 1'b0;
      drain("R4");

      // R2: plain pulse from the reset port once more
      cur_tag = "R2";
      io_write(16'h0CF9, 8'h00);
      expect_pulse(1, LEN, "R2");
      io_write(16'h0CF9, 8'h04);
      drain("R2");

      summary();
   end

endmodule